// File: doc/BRIEF.md
# Serial Adapter Register and Interrupt Unit

This unit is the processor-facing half of an asynchronous serial adapter. A small CPU bus reaches four byte-wide registers through a two-bit offset. Offset 0 is the data port, offset 1 is the status port, offset 2 holds the command byte and offset 3 holds the line-format byte. The unit passes each byte delivered by a receiver block to the CPU and each byte written by the CPU to a transmitter block. It drives the modem-control outputs DTR and RTS and synchronises the carrier-detect and data-set-ready inputs, latching any change on them. It merges every pending source into a single active-low interrupt line.

The unit has no bit-level serialiser and no baud timing. Separate blocks do that work: they read the line-format byte, the parity field and the echo flag from this unit's outputs. The receiver offers bytes as one-cycle strobes together with its error flags. The transmitter takes the held byte with a one-cycle strobe. The carrier level only shows up in status. It never gates the receiver, so incoming data is accepted while carrier is absent.

Top module: `serial_reg_block`

## Requirements
- R1: After hardware reset the command and line-format bytes read 0x00. With both modem inputs high, status reads 0x70. irqN, dtrN and rtsN are high, and txPending and rxEnable are low.
- R2: A write to offset 2 or offset 3 stores the byte and reads back unchanged at that offset. parityMode carries command bits 7:5, echoOn carries command bit 4, and frameCfg carries the line-format byte.
- R3: Any write to offset 1 clears command bits 4:0, the modem-change latch and the overrun flag. It leaves command bits 7:5 and the line-format byte unchanged, so DTR, RTS and the interrupt all go inactive.
- R4: While command bit 0 is set, an rxValid strobe makes offset 0 return rxByte and sets status bit 3. It loads status bit 1 from rxFrameErr and status bit 0 from rxParityErr. While command bit 0 is clear, the strobe is ignored.
- R5: A read of offset 0 clears status bit 3. A byte accepted while bit 3 is still set sets status bit 2 (overrun) and replaces the held byte. The next byte accepted with bit 3 clear clears bit 2 again.
- R6: A write to offset 0 puts the byte on txByte, raises txPending and clears status bit 4. A txTake strobe then lowers txPending and sets bit 4 again.
- R7: dtrN is the inverse of command bit 0. rtsN is high only when command bits 3:2 are 00, and low for 01, 10 and 11.
- R8: Status bit 6 shows the carrierN level and status bit 5 shows the readyN level, each after the synchroniser. Any level change on either input sets the modem-change latch.
- R9: irqN is low exactly when command bit 0 is set and at least one of these holds: the modem-change latch is set; status bit 3 is set while command bit 1 is 0; status bit 4 is set while command bits 3:2 are 01. Status bit 7 reads as the inverse of irqN.
- R10: A read of offset 1 clears the modem-change latch.
- R11: rxEnable follows command bit 0 alone, whatever the carrierN level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| busWr | input | 1 | Write strobe for the register at busAddr |
| busRd | input | 1 | Read strobe; enables the read side effects |
| busAddr | input | 2 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| rxValid | input | 1 | Receiver delivers a byte this cycle |
| rxByte | input | 8 | Received byte |
| rxFrameErr | input | 1 | Framing error on the delivered byte |
| rxParityErr | input | 1 | Parity error on the delivered byte |
| rxEnable | output | 1 | Receiver enable |
| txTake | input | 1 | Transmitter takes the held byte |
| txByte | output | 8 | Byte held for the transmitter |
| txPending | output | 1 | A byte is waiting for the transmitter |
| carrierN | input | 1 | Carrier detect, active low |
| readyN | input | 1 | Data set ready, active low |
| dtrN | output | 1 | Data terminal ready, active low |
| rtsN | output | 1 | Request to send, active low |
| irqN | output | 1 | Interrupt request, active low |
| parityMode | output | 3 | Parity field for the serial blocks |
| echoOn | output | 1 | Echo mode for the serial blocks |
| frameCfg | output | 8 | Line-format byte for the serial blocks |

## Verification
The main stimulus is a random stream of single operations: command and format writes, data writes, receiver strobes with random error flags, transmitter takes, status and data reads, and program resets. Random command bytes walk through every combination of master enable, receive-interrupt enable and transmit-mode field. This exposes a wrong interrupt qualification, which a hand-picked byte would mask. The directed cases follow. Two unread bytes in a row separate overrun from a simple refresh. A strobe with the master enable clear separates "ignored" from "stored". A modem edge followed by a status read shows that the change latch is cleared by the read and not by the edge going away. A program reset issued over a command byte with its parity bits set shows which bits survive.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFF_DATA   = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_FMT    = 2'd3;

  // one-cycle strobes from the decode/control side into the datapath
  typedef struct packed {
    logic wrData;
    logic wrStatus;
    logic wrCmd;
    logic wrFmt;
    logic rdData;
    logic rdStatus;
  } regStrobes_t;
endpackage

// File: rtl/serial_reg_ctrl.sv
module serial_reg_ctrl
  import serial_reg_pkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        cmdLow,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              modemChg,
  output regStrobes_t       strobes,
  output logic              irqActive,
  output logic              irqN,
  output logic              dtrN,
  output logic              rtsN,
  output logic              rxEnable
);
  logic masterOn;
  logic rxIrqOn;
  logic txIrqOn;

  assign masterOn = cmdLow[0];
  assign rxIrqOn  = ~cmdLow[1];
  assign txIrqOn  = (cmdLow[3:2] == 2'b01);

  always_comb begin
    strobes          = '0;
    strobes.wrData   = busWr && (busAddr == OFF_DATA);
    strobes.wrStatus = busWr && (busAddr == OFF_STATUS);
    strobes.wrCmd    = busWr && (busAddr == OFF_CMD);
    strobes.wrFmt    = busWr && (busAddr == OFF_FMT);
    strobes.rdData   = busRd && !busWr && (busAddr == OFF_DATA);
    strobes.rdStatus = busRd && !busWr && (busAddr == OFF_STATUS);
  end

  assign irqActive = masterOn &&
                     (modemChg || (rxFull && rxIrqOn) || (txEmpty && txIrqOn));
  assign irqN      = ~irqActive;
  assign dtrN      = ~masterOn;
  assign rtsN      = (cmdLow[3:2] == 2'b00);
  assign rxEnable  = masterOn;
endmodule

// File: rtl/serial_reg_dp.sv
module serial_reg_dp
  import serial_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              irqActive,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic              txTake,
  input  logic              carrierN,
  input  logic              readyN,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] fmtReg,
  output logic [DATA_W-1:0] txHold,
  output logic              rxFull,
  output logic              txEmpty,
  output logic              modemChg,
  output logic [DATA_W-1:0] statusWord
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [DATA_W-1:0] rxHold;
  logic              overrun, frameErr, parityErr;
  logic [1:0]        syncQ [SYNC_STAGES];
  logic [1:0]        modemPrev;
  logic              modemEdge;

  // modem input synchroniser: {carrier, ready}
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 2'b11;
        else       syncQ[g] <= {carrierN, readyN};
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 2'b11;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign modemEdge = (syncQ[LAST] != modemPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modemPrev <= 2'b11;
      modemChg  <= 1'b0;
    end else begin
      modemPrev <= syncQ[LAST];
      if (modemEdge)                              modemChg <= 1'b1;
      else if (strobes.rdStatus || strobes.wrStatus) modemChg <= 1'b0;
    end
  end

  // command and line-format bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      fmtReg <= '0;
    end else begin
      if (strobes.wrCmd)         cmdReg      <= busWdata;
      else if (strobes.wrStatus) cmdReg[4:0] <= 5'b0;
      if (strobes.wrFmt)         fmtReg      <= busWdata;
    end
  end

  // transmit holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txEmpty <= 1'b1;
    end else if (strobes.wrData) begin
      txHold  <= busWdata;
      txEmpty <= 1'b0;
    end else if (txTake) begin
      txEmpty <= 1'b1;
    end
  end

  // receive holding register and per-byte error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold    <= '0;
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
    end else if (rxValid && cmdReg[0]) begin
      rxHold    <= rxByte;
      overrun   <= rxFull;
      frameErr  <= rxFrameErr;
      parityErr <= rxParityErr;
      rxFull    <= 1'b1;
    end else begin
      if (strobes.rdData)   rxFull  <= 1'b0;
      if (strobes.wrStatus) overrun <= 1'b0;
    end
  end

  assign statusWord = {irqActive, syncQ[LAST], ~txEmpty ? 1'b0 : 1'b1,
                       rxFull, overrun, frameErr, parityErr};

  always_comb begin
    unique case (busAddr)
      OFF_DATA:   busRdata = rxHold;
      OFF_STATUS: busRdata = statusWord;
      OFF_CMD:    busRdata = cmdReg;
      default:    busRdata = fmtReg;
    endcase
  end
endmodule

// File: rtl/serial_reg_block.sv
module serial_reg_block
  import serial_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  output logic              rxEnable,
  input  logic              txTake,
  output logic [DATA_W-1:0] txByte,
  output logic              txPending,
  input  logic              carrierN,
  input  logic              readyN,
  output logic              dtrN,
  output logic              rtsN,
  output logic              irqN,
  output logic [2:0]        parityMode,
  output logic              echoOn,
  output logic [DATA_W-1:0] frameCfg
);
  regStrobes_t       strobes;
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] statusWord;
  logic              rxFull, txEmpty, modemChg, irqActive;

  serial_reg_ctrl i_ctrl (
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .cmdLow   (cmdReg[3:0]),
    .rxFull   (rxFull),
    .txEmpty  (txEmpty),
    .modemChg (modemChg),
    .strobes  (strobes),
    .irqActive(irqActive),
    .irqN     (irqN),
    .dtrN     (dtrN),
    .rtsN     (rtsN),
    .rxEnable (rxEnable)
  );

  serial_reg_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .irqActive  (irqActive),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .rxFrameErr (rxFrameErr),
    .rxParityErr(rxParityErr),
    .txTake     (txTake),
    .carrierN   (carrierN),
    .readyN     (readyN),
    .cmdReg     (cmdReg),
    .fmtReg     (frameCfg),
    .txHold     (txByte),
    .rxFull     (rxFull),
    .txEmpty    (txEmpty),
    .modemChg   (modemChg),
    .statusWord (statusWord)
  );

  assign txPending  = ~txEmpty;
  assign parityMode = cmdReg[7:5];
  assign echoOn     = cmdReg[4];
endmodule

// File: rtl/serial_reg_chk.sv
module serial_reg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busWdata,
  input logic       rxValid,
  input logic       rxEnable,
  input logic       txPending,
  input logic       dtrN,
  input logic       rtsN,
  input logic       irqN,
  input logic [7:0] statusWord
);
  assert_prog_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd1) |=> (dtrN && rtsN && irqN));

  assert_rx_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxEnable) |=> statusWord[3]);

  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxEnable && statusWord[3]) |=> statusWord[2]);

  assert_tx_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0) |=> txPending);

  assert_dtr_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd2) |=> (dtrN == !$past(busWdata[0])));

  assert_master_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    dtrN |-> irqN);
endmodule

bind serial_reg_block serial_reg_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .rxValid   (rxValid),
  .rxEnable  (rxEnable),
  .txPending (txPending),
  .dtrN      (dtrN),
  .rtsN      (rtsN),
  .irqN      (irqN),
  .statusWord(statusWord)
);

// File: tb/test_serial_reg_block.sv
module test_serial_reg_block;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'd0;
  logic       rxFrameErr = 1'b0, rxParityErr = 1'b0;
  logic       rxEnable;
  logic       txTake = 1'b0;
  logic [7:0] txByte;
  logic       txPending;
  logic       carrierN = 1'b1, readyN = 1'b1;
  logic       dtrN, rtsN, irqN;
  logic [2:0] parityMode;
  logic       echoOn;
  logic [7:0] frameCfg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0] mCmd = 8'h00, mFmt = 8'h00, mRx = 8'h00, mTx = 8'h00;
  logic       mRxFull = 1'b0, mOvr = 1'b0, mFe = 1'b0, mPe = 1'b0;
  logic       mTxEmpty = 1'b1, mChg = 1'b0, mDcd = 1'b1, mDsr = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_block i_serial_reg_block (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxByte(rxByte),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxEnable(rxEnable),
    .txTake(txTake), .txByte(txByte), .txPending(txPending), .carrierN(carrierN),
    .readyN(readyN), .dtrN(dtrN), .rtsN(rtsN), .irqN(irqN),
    .parityMode(parityMode), .echoOn(echoOn), .frameCfg(frameCfg)
  );

  function automatic logic expIrq();
    return mCmd[0] & (mChg | (mRxFull & ~mCmd[1]) | (mTxEmpty & (mCmd[3:2] == 2'b01)));
  endfunction

  function automatic logic [7:0] expStatus();
    return {expIrq(), mDcd, mDsr, mTxEmpty, mRxFull, mOvr, mFe, mPe};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic checkAll();
    logic [7:0] v;
    peek(2'd1, v); check("R4/R5/R6/R8 status", v, expStatus());
    peek(2'd2, v); check("R2 command", v, mCmd);
    peek(2'd3, v); check("R2 format", v, mFmt);
    peek(2'd0, v); check("R4 data", v, mRx);
    check("R2 parity/echo/frame", {parityMode, echoOn, 4'h0}, {mCmd[7:4], 4'h0});
    check("R2 frameCfg", frameCfg, mFmt);
    check("R9 irqN", {7'd0, irqN}, {7'd0, ~expIrq()});
    check("R7 dtrN/rtsN", {6'd0, dtrN, rtsN}, {6'd0, ~mCmd[0], mCmd[3:2] == 2'b00});
    check("R11 rxEnable", {7'd0, rxEnable}, {7'd0, mCmd[0]});
    check("R6 txPending", {7'd0, txPending}, {7'd0, ~mTxEmpty});
    if (!mTxEmpty) check("R6 txByte", txByte, mTx);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); busAddr = a; busWdata = v; busWr = 1'b1;
    @(posedge clk); #1 busWr = 1'b0;
    case (a)
      2'd0: begin mTx = v; mTxEmpty = 1'b0; end
      2'd1: begin mCmd = mCmd & 8'hE0; mChg = 1'b0; mOvr = 1'b0; end
      2'd2: mCmd = v;
      default: mFmt = v;
    endcase
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    @(posedge clk); #1 busRd = 1'b0;
    if (a == 2'd0) mRxFull = 1'b0;
    if (a == 2'd1) mChg = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b, input logic fe, input logic pe);
    @(negedge clk); rxByte = b; rxFrameErr = fe; rxParityErr = pe; rxValid = 1'b1;
    @(posedge clk); #1 rxValid = 1'b0;
    if (mCmd[0]) begin
      mOvr = mRxFull; mRx = b; mFe = fe; mPe = pe; mRxFull = 1'b1;
    end
  endtask

  task automatic txPull();
    @(negedge clk); txTake = 1'b1;
    @(posedge clk); #1 txTake = 1'b0;
    mTxEmpty = 1'b1;
  endtask

  task automatic setModem(input logic c, input logic r);
    @(negedge clk); carrierN = c; readyN = r;
    repeat (4) @(posedge clk);
    #1;
    if (c != mDcd || r != mDsr) mChg = 1'b1;
    mDcd = c; mDsr = r;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    peek(2'd1, v); check("R1 status after reset", v, 8'h70);
    checkAll();

    // R2 and R7: configure
    busWrite(2'd3, 8'h1A);
    busWrite(2'd2, 8'hE9);
    checkAll();

    // R4: received byte with framing error, rx interrupt (R9)
    rxPush(8'h5A, 1'b1, 1'b0);
    check("R4 irq on receive", {7'd0, irqN}, 8'h00);
    checkAll();

    // R5: overrun then clear
    rxPush(8'hA5, 1'b0, 1'b1);
    peek(2'd1, v); check("R5 overrun set", {5'd0, v[2:0]}, 8'h05);
    checkAll();
    busRead(2'd0, v); check("R5 data read value", v, 8'hA5);
    checkAll();
    rxPush(8'h33, 1'b0, 1'b0);
    peek(2'd1, v); check("R5 overrun cleared by clean byte", {7'd0, v[2]}, 8'h00);
    busRead(2'd0, v);
    checkAll();

    // R6: transmit path
    busWrite(2'd0, 8'h77);
    check("R6 txByte", txByte, 8'h77);
    checkAll();
    txPull();
    checkAll();
    txPull(); // take with nothing pending: no change
    checkAll();

    // R9: transmit interrupt; R11/R7: master off; R4 ignored byte
    busWrite(2'd2, 8'h05);
    check("R9 tx-empty irq", {7'd0, irqN}, 8'h00);
    checkAll();
    busWrite(2'd2, 8'h04);
    checkAll();
    rxPush(8'hC3, 1'b1, 1'b1);
    peek(2'd1, v); check("R4 byte ignored with master off", {4'd0, v[3:0]}, 8'h00);
    peek(2'd0, v); check("R4 data unchanged when ignored", v, 8'h33);
    checkAll();

    // R8, R10, R11: modem change
    busWrite(2'd2, 8'h0B);
    setModem(1'b0, 1'b1);
    check("R8 carrier change irq", {7'd0, irqN}, 8'h00);
    check("R11 receiver on regardless of carrier", {7'd0, rxEnable}, 8'h01);
    checkAll();
    busRead(2'd1, v); check("R10 status bit7 before read", {7'd0, v[7]}, 8'h01);
    check("R10 irq cleared by status read", {7'd0, irqN}, 8'h01);
    checkAll();

    // R3: program reset keeps parity bits and format
    busWrite(2'd2, 8'hAB);
    setModem(1'b0, 1'b0);
    checkAll();
    busWrite(2'd1, 8'h5C);
    peek(2'd2, v); check("R3 command after program reset", v, 8'hA0);
    peek(2'd3, v); check("R3 format kept", v, 8'h1A);
    checkAll();
    busWrite(2'd2, 8'h0B);
    check("R3 change latch cleared", {7'd0, irqN}, 8'h01);
    checkAll();
    setModem(1'b1, 1'b1);
    busRead(2'd1, v);
    checkAll();

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 9);
      case (op)
        0, 1: busWrite(2'd2, 8'($urandom));
        2: busWrite(2'd3, 8'($urandom));
        3: busWrite(2'd0, 8'($urandom));
        4: rxPush(8'($urandom), 1'($urandom), 1'($urandom));
        5: txPull();
        6: busRead(2'd1, v);
        7: busRead(2'd0, v);
        default: busWrite(2'd1, 8'($urandom));
      endcase
      checkAll();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule